// File: doc/BRIEF.md
# Keyboard Scan Code Receiver

This block takes the two open-collector lines of a PS/2 keyboard, clock and data, and turns each 11-bit frame into one byte held in a small register file that an 8-bit CPU reads over a simple address, strobe and data bus. Both lines are asynchronous to the system clock. Each one passes through a synchronizer and a glitch filter before the frame logic uses it. A frame is a start bit of 0, eight data bits sent least significant bit first, an odd parity bit and a stop bit of 1. The frame logic samples each bit on the filtered falling edge of the keyboard clock.

Firmware takes each code through a handshake. It polls the code register until it reads a non-zero value, then writes the acknowledge address, and the code register returns to zero. An interrupt output stays high from the moment a code is stored until it is acknowledged. Bytes are stored exactly as received. Break prefixes, make codes and auto-repeated make codes each go through the handshake as separate bytes. Pairing make and break codes is left to software.

The receiver drops a frame that has a bad start bit, bad parity or a missing stop bit. If a frame stalls in the middle, the receiver gives it up after a timeout. A byte that completes while an earlier code is still waiting for acknowledge is discarded, and a sticky overrun flag is set.

Top module: `ps2_scan_port`

## Requirements
- R1: After reset, address 0 (code) reads 0x00, address 1 (status) reads 0x00 and irq_o is low.
- R2: A well-formed frame stores its eight data bits (least significant bit first on the line) at address 0. It sets status bit 0 (pending) and raises irq_o. A received 0x00 is also marked pending.
- R3: Every byte value, including the 0xF0 break prefix and repeated identical make codes, is delivered unchanged, one handshake per byte.
- R4: A write to address 1 (any data) clears the code to 0x00, clears pending and overrun, and drops irq_o in the next cycle.
- R5: A frame whose parity bit does not make the nine bits odd is discarded, and the code and status stay unchanged.
- R6: A frame whose stop bit is 0 is discarded, and the code and status stay unchanged.
- R7: A falling clock edge with data high while idle is not taken as a start bit, and the next frame is received correctly.
- R8: A byte completing while pending is set is dropped: the code keeps the earlier value and status bit 1 (overrun) is set until acknowledge.
- R9: If no falling clock edge arrives for TIMEOUT_CYC system cycles inside a frame, the partial frame is abandoned, and the next full frame is received correctly.
- R10: A pulse on either keyboard line shorter than FILT_LEN system cycles has no effect.
- R11: Address 1 reads {6'b0, overrun, pending}, and unused addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| kb_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| kb_dat_i | input | 1 | Keyboard data line (asynchronous) |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data (ignored) |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Code waiting for acknowledge |

## Verification
The hardest case to reach from the ports is a receiver that has lost frame alignment. This happens after a glitch is wrongly taken as a start bit, or after a frame stalls partway through. In either case the error only shows up in the byte of a later, valid frame. The bench brings the receiver into that state on purpose: it emits a 2-cycle low pulse on the clock line with data low, or it sends a start bit and three data bits and then goes silent for longer than the timeout. It then sends a complete frame and compares the stored byte against the intended value. A full sweep of all 256 byte values also covers the bit ordering and the parity of every code.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned FRAME_LEN = 11;

  typedef enum logic [ADDR_W-1:0] {
    REG_CODE = 2'd0,
    REG_STAT = 2'd1
  } reg_addr_e;

  localparam int unsigned ST_PEND = 0;
  localparam int unsigned ST_OVR  = 1;
endpackage

// File: rtl/ps2_line_filt.sv
module ps2_line_filt #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  // output flips only after FILT_LEN consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
    end else if (synced == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      cnt_q  <= '0;
      filt_q <= synced;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign line_o = filt_q;

  // R10: a change at the output is backed by the synchronized input
  a_r10_filter_backed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(synced) == filt_q));
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx #(
  parameter int unsigned TIMEOUT_CYC = 12500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kclk_i,
  input  logic       kdat_i,
  output logic       valid_o,
  output logic [7:0] byte_o
);
  import ps2_rx_pkg::*;
  localparam int unsigned BW = $clog2(FRAME_LEN);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

  logic          kclk_q;
  logic          fall;
  logic [BW-1:0] bit_q;
  logic [7:0]    sh_q;
  logic          par_q;
  logic          par_ok_q;
  logic [TW-1:0] tmo_q;
  logic          tmo_hit;
  logic          valid_q;

  assign fall    = kclk_q & ~kclk_i;
  assign tmo_hit = (bit_q != '0) && (tmo_q == TW'(TIMEOUT_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kclk_q <= 1'b1;
    else         kclk_q <= kclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tmo_q <= '0;
    else if (fall || bit_q == '0) tmo_q <= '0;
    else if (!tmo_hit)         tmo_q <= tmo_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= '0;
      sh_q     <= '0;
      par_q    <= 1'b0;
      par_ok_q <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tmo_hit) begin
        bit_q <= '0;
      end else if (fall) begin
        if (bit_q == '0) begin
          if (!kdat_i) begin
            bit_q <= BW'(1);
            par_q <= 1'b0;
          end
        end else if (bit_q <= BW'(8)) begin
          sh_q  <= {kdat_i, sh_q[7:1]};
          par_q <= par_q ^ kdat_i;
          bit_q <= bit_q + 1'b1;
        end else if (bit_q == BW'(9)) begin
          par_ok_q <= par_q ^ kdat_i;
          bit_q    <= bit_q + 1'b1;
        end else begin
          valid_q <= par_ok_q & kdat_i;
          bit_q   <= '0;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign byte_o  = sh_q;

  a_r2_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r9_timeout_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q <= TW'(TIMEOUT_CYC));
  a_r9_bit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q < BW'(FRAME_LEN));
endmodule

// File: rtl/ps2_code_buf.sv
module ps2_code_buf (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  input  logic       ack_i,
  output logic [7:0] code_o,
  output logic       pend_o,
  output logic       ovr_o
);
  logic [7:0] code_q;
  logic       pend_q;
  logic       ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (ack_i) begin
      code_q <= valid_i ? byte_i : 8'h00;
      pend_q <= valid_i;
      ovr_q  <= 1'b0;
    end else if (valid_i) begin
      if (pend_q) begin
        ovr_q <= 1'b1;
      end else begin
        code_q <= byte_i;
        pend_q <= 1'b1;
      end
    end
  end

  assign code_o = code_q;
  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;

  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (pend_q == $past(valid_i)) && !ovr_q);
  a_r8_overrun_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && valid_i && !ack_i) |=> (ovr_q && $stable(code_q)));
  a_r8_ovr_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> pend_q);
endmodule

// File: rtl/ps2_scan_port.sv
module ps2_scan_port #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4,
  parameter int unsigned TIMEOUT_CYC = 12500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       kb_clk_i,
  input  logic       kb_dat_i,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  import ps2_rx_pkg::*;

  logic [1:0] raw;
  logic [1:0] filt;
  logic       valid;
  logic [7:0] rx_byte;
  logic [7:0] code;
  logic       pend;
  logic       ovr;
  logic       ack;
  logic       unused_w;

  assign raw      = {kb_dat_i, kb_clk_i};
  assign unused_w = ^wdata_i;

  for (genvar g = 0; g < 2; g++) begin : g_line
    ps2_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(raw[g]), .line_o(filt[g]));
  end

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .kclk_i(filt[0]), .kdat_i(filt[1]),
    .valid_o(valid), .byte_o(rx_byte));

  assign ack = wr_i && (addr_i == REG_STAT);

  ps2_code_buf i_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid), .byte_i(rx_byte),
    .ack_i(ack), .code_o(code), .pend_o(pend), .ovr_o(ovr));

  always_comb begin
    rdata_o = 8'h00;
    unique case (addr_i)
      REG_CODE: rdata_o = code;
      REG_STAT: begin
        rdata_o[ST_PEND] = pend;
        rdata_o[ST_OVR]  = ovr;
      end
      default: rdata_o = {7'd0, unused_w & 1'b0};
    endcase
  end

  assign irq_o = pend;

  a_r4_irq_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !valid) |=> !irq_o);
endmodule

// File: tb/test_ps2_scan_port.sv
module test_ps2_scan_port;
  localparam int HP  = 12;
  localparam int TMO = 100;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       kb_clk = 1'b1;
  logic       kb_dat = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h5a;
  logic [7:0] rdata;
  logic       irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ps2_scan_port #(.SYNC_STAGES(2), .FILT_LEN(4), .TIMEOUT_CYC(TMO)) i_ps2_scan_port (
    .clk_i(clk), .rst_ni(rst_ni), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic ack();
    addr = 2'd1; wr = 1'b1;
    cyc(1);
    wr = 1'b0;
    cyc(1);
  endtask

  task automatic bit_out(input logic b);
    kb_dat = b;
    cyc(HP);
    kb_clk = 1'b0;
    cyc(HP);
    kb_clk = 1'b1;
  endtask

  task automatic frame(input logic [7:0] d, input logic bad_par, input logic stop);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    bit_out(~^d ^ bad_par);
    bit_out(stop);
    kb_dat = 1'b1;
    cyc(20);
  endtask

  task automatic expect_state(input string req, input int code, input int stat);
    logic [7:0] v;
    rd(2'd0, v); chk(req, v, code);
    rd(2'd1, v); chk(req, v, stat);
    chk(req, irq, stat & 1);
  endtask

  initial begin
    logic [7:0] v;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    expect_state("R1", 0, 0);
    rd(2'd2, v); chk("R11", v, 0);
    rd(2'd3, v); chk("R11", v, 0);

    // R2 R3: sweep every byte value through the handshake
    for (int b = 0; b < 256; b++) begin
      frame(8'(b), 1'b0, 1'b1);
      expect_state("R2", b, 1);
      ack();
      expect_state("R4", 0, 0);
    end

    // R3: break prefix and repeated make codes each delivered
    begin
      logic [7:0] seq [5] = '{8'h1c, 8'h1c, 8'h1c, 8'hf0, 8'h1c};
      for (int i = 0; i < 5; i++) begin
        frame(seq[i], 1'b0, 1'b1);
        expect_state("R3", seq[i], 1);
        ack();
      end
    end

    // R5 bad parity, R6 bad stop
    frame(8'h3a, 1'b1, 1'b1);
    expect_state("R5", 0, 0);
    frame(8'h3a, 1'b0, 1'b0);
    cyc(3 * HP);
    expect_state("R6", 0, 0);
    frame(8'h3a, 1'b0, 1'b1);
    expect_state("R6", 8'h3a, 1);
    ack();

    // R7: falling edge with data high while idle
    bit_out(1'b1);
    cyc(20);
    expect_state("R7", 0, 0);
    frame(8'h71, 1'b0, 1'b1);
    expect_state("R7", 8'h71, 1);
    ack();

    // R8: overrun
    frame(8'h22, 1'b0, 1'b1);
    frame(8'h44, 1'b0, 1'b1);
    expect_state("R8", 8'h22, 3);
    ack();
    expect_state("R8", 0, 0);
    frame(8'h44, 1'b0, 1'b1);
    expect_state("R8", 8'h44, 1);
    ack();

    // R9: stalled partial frame then full frame
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    kb_dat = 1'b1;
    cyc(3 * TMO);
    expect_state("R9", 0, 0);
    frame(8'h96, 1'b0, 1'b1);
    expect_state("R9", 8'h96, 1);
    ack();

    // R10: short pulses on clock (data low) and on data
    kb_dat = 1'b0; cyc(HP);
    kb_clk = 1'b0; cyc(2); kb_clk = 1'b1;
    kb_dat = 1'b1; cyc(HP);
    kb_dat = 1'b0; cyc(2); kb_dat = 1'b1; cyc(HP);
    expect_state("R10", 0, 0);
    frame(8'ha5, 1'b0, 1'b1);
    expect_state("R10", 8'ha5, 1);
    ack();

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 180000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule